// File: doc/BRIEF.md
# Shift and Subtract Execute Slice with Condition Flag

This block is one execute slice of a 32-bit integer pipeline. Each cycle it takes a decoded operation select, two register operands, a 16-bit immediate and a 5-bit immediate. From these it forms a destination value, a destination write enable and the instruction length in bytes. The caller uses the length to advance the program counter. The slice covers three forms of logical right shift and three kinds of subtraction. It also holds the single condition flag that two of the subtractions write.

All outputs except the flag are combinational from the current inputs. The flag is a register. It is read in the same cycle by the borrow-chaining subtraction, and it is written on the clock edge that ends a valid flag-writing operation. Register file access, decode and memory sit around the slice and are not part of it.

Top module: `shsub_exec_unit`

## Requirements
- R1: After a cycle with `rst` high, `cond_out` is 0.
- R2: Operation code 0 (register shift) gives `result = dst_val >> src_val[4:0]`. The upper bits are filled with zeros and a count of 0 returns `dst_val` unchanged. `result_we` is 1 and `insn_bytes` is 2.
- R3: Operation code 1 (three-operand shift) gives `result = src_val >> imm16[4:0]`. Bits 15..5 of the immediate are ignored. `insn_bytes` is 4.
- R4: Operation code 2 (immediate shift) gives `result = dst_val >> imm5`. `insn_bytes` is 2.
- R5: Operation code 3 (plain subtract) gives `result = dst_val - src_val` modulo 2^32 and leaves the flag unchanged. `insn_bytes` is 2.
- R6: Operation code 4 gives `result = dst_val - src_val` and loads the flag with the signed overflow of that subtraction. Overflow is 1 when the operand sign bits differ and the result sign differs from the sign of `dst_val`.
- R7: Operation code 5 gives `result = dst_val - src_val - flag`, where flag is the current flag value. It loads the flag with the borrow out, which is 1 exactly when `dst_val < src_val + flag` as unsigned numbers.
- R8: With `op_valid` low, `result_we` is 0 and the flag holds its value across the clock edge.
- R9: Operation codes 6 and 7 are unassigned. They give `result_we = 0` and `insn_bytes = 2`, and they leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (0..5 assigned) |
| dst_val | input | 32 | Destination register operand (minuend, in-place shift source) |
| src_val | input | 32 | Source register operand (subtrahend, shift count, three-operand shift source) |
| imm16 | input | 16 | Signed 16-bit immediate; low five bits give the shift count |
| imm5 | input | 5 | Unsigned 5-bit shift count |
| result | output | 32 | Destination value |
| result_we | output | 1 | Destination write enable |
| cond_out | output | 1 | Condition flag register |
| insn_bytes | output | 3 | Instruction length in bytes (2 or 4) |

## Verification
In a single cycle the borrow subtraction both reads the flag into its difference and writes a new flag from its borrow out. The same happens when an overflow subtraction is followed directly by a borrow subtraction. The bench provokes this with back-to-back subtractions across a grid of corner operands: 0, 1, the sign boundaries and all ones. The flag is left at both 0 and 1 going in. Each result is judged against a bench model whose flag is updated only after that cycle's difference has been computed from the old flag.

// File: rtl/shsub_pkg.sv
package shsub_pkg;

    localparam int XLEN  = 32;
    localparam int IMM_W = 16;
    localparam int CNT_W = $clog2(XLEN);

    typedef enum logic [2:0] {
        OP_SHR_REG   = 3'd0,
        OP_SHR_IMM16 = 3'd1,
        OP_SHR_IMM5  = 3'd2,
        OP_SUB       = 3'd3,
        OP_SUB_OVF   = 3'd4,
        OP_SUB_BRW   = 3'd5,
        OP_RSV6      = 3'd6,
        OP_RSV7      = 3'd7
    } exec_op_e;

    typedef struct packed {
        logic [XLEN-1:0] diff;
        logic            ovf;
        logic            borrow;
    } sub_res_t;

    function automatic logic op_is_legal(exec_op_e op);
        return (op != OP_RSV6) && (op != OP_RSV7);
    endfunction

    function automatic logic op_is_shift(exec_op_e op);
        return (op == OP_SHR_REG) || (op == OP_SHR_IMM16) || (op == OP_SHR_IMM5);
    endfunction

    function automatic logic [2:0] op_length(exec_op_e op);
        return (op == OP_SHR_IMM16) ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [CNT_W-1:0] imm_count(logic [IMM_W-1:0] imm);
        return imm[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/shsub_shifter.sv
module shsub_shifter #(
    parameter int W     = 32,
    parameter int CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stage [0:CNT_W];

    assign stage[0] = din;

    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        assign stage[i+1] = cnt[i] ? (stage[i] >> (2 ** i)) : stage[i];
    end

    assign dout = stage[CNT_W];
endmodule

// File: rtl/shsub_subtractor.sv
module shsub_subtractor
    import shsub_pkg::*;
(
    input  logic [XLEN-1:0] minuend,
    input  logic [XLEN-1:0] subtrahend,
    input  logic            borrow_in,
    output sub_res_t        res
);
    logic [XLEN:0] wide;

    always_comb begin
        wide       = {1'b0, minuend} - {1'b0, subtrahend} - {{XLEN{1'b0}}, borrow_in};
        res.diff   = wide[XLEN-1:0];
        res.borrow = wide[XLEN];
        res.ovf    = (minuend[XLEN-1] != subtrahend[XLEN-1]) &&
                     (wide[XLEN-1] != minuend[XLEN-1]);
    end
endmodule

// File: rtl/shsub_cond_reg.sv
module shsub_cond_reg (
    input  logic clk,
    input  logic rst,
    input  logic upd_en,
    input  logic upd_val,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (upd_en)
            q <= upd_val;
    end
endmodule

// File: rtl/shsub_exec_unit.sv
module shsub_exec_unit
    import shsub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_sel,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm16,
    input  logic [CNT_W-1:0] imm5,
    output logic [XLEN-1:0]  result,
    output logic             result_we,
    output logic             cond_out,
    output logic [2:0]       insn_bytes
);
    exec_op_e         op;
    logic [XLEN-1:0]  sh_in;
    logic [CNT_W-1:0] sh_cnt;
    logic [XLEN-1:0]  sh_out;
    logic             brw_in;
    sub_res_t         sub_out;
    logic             cond_upd;
    logic             cond_nxt;

    assign op = exec_op_e'(op_sel);

    always_comb begin
        sh_in  = dst_val;
        sh_cnt = src_val[CNT_W-1:0];
        unique case (op)
            OP_SHR_IMM16: begin
                sh_in  = src_val;
                sh_cnt = imm_count(imm16);
            end
            OP_SHR_IMM5: sh_cnt = imm5;
            default: ;
        endcase
    end

    shsub_shifter #(.W(XLEN), .CNT_W(CNT_W)) u_shift (
        .din  (sh_in),
        .cnt  (sh_cnt),
        .dout (sh_out)
    );

    assign brw_in = (op == OP_SUB_BRW) && cond_out;

    shsub_subtractor u_sub (
        .minuend    (dst_val),
        .subtrahend (src_val),
        .borrow_in  (brw_in),
        .res        (sub_out)
    );

    always_comb begin
        cond_upd = op_valid && ((op == OP_SUB_OVF) || (op == OP_SUB_BRW));
        cond_nxt = (op == OP_SUB_OVF) ? sub_out.ovf : sub_out.borrow;
    end

    shsub_cond_reg u_cond (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (cond_upd),
        .upd_val (cond_nxt),
        .q       (cond_out)
    );

    assign result     = op_is_shift(op) ? sh_out : sub_out.diff;
    assign result_we  = op_valid && op_is_legal(op);
    assign insn_bytes = op_length(op);
endmodule

// File: rtl/shsub_exec_unit_chk.sv
module shsub_exec_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_sel,
    input logic [31:0] dst_val,
    input logic [31:0] src_val,
    input logic [31:0] result,
    input logic        result_we,
    input logic        cond_out,
    input logic [2:0]  insn_bytes
);
    AST_COND_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cond_out); // R1

    AST_SHR_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd0 && src_val[4:0] != 5'd0) |-> !result[31]); // R2

    AST_LONG_FORM: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd1) |-> (insn_bytes == 3'd4)); // R3

    AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd3) |-> (result + src_val == dst_val)); // R5

    AST_SUB_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd3) |=> $stable(cond_out)); // R5

    AST_BORROW_OUT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd5) |=>
        (cond_out == ({1'b0, $past(dst_val)} < ({1'b0, $past(src_val)} + {32'd0, $past(cond_out)})))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(cond_out)); // R8

    AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_sel[2:1] == 2'b11) |-> (!result_we && insn_bytes == 3'd2)); // R9
endmodule

bind shsub_exec_unit shsub_exec_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .dst_val    (dst_val),
    .src_val    (src_val),
    .result     (result),
    .result_we  (result_we),
    .cond_out   (cond_out),
    .insn_bytes (insn_bytes)
);

// File: tb/tb_shsub_exec_unit.sv
module tb_shsub_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] dst_val = 32'd0;
    logic [31:0] src_val = 32'd0;
    logic [15:0] imm16 = 16'd0;
    logic [4:0]  imm5 = 5'd0;
    logic [31:0] result;
    logic        result_we;
    logic        cond_out;
    logic [2:0]  insn_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic model_c = 1'b0;

    always #2.5 clk = ~clk;

    shsub_exec_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .dst_val(dst_val), .src_val(src_val), .imm16(imm16), .imm5(imm5),
        .result(result), .result_we(result_we), .cond_out(cond_out),
        .insn_bytes(insn_bytes)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation, check combinational outputs, then the flag after the edge.
    task automatic run_op(input string req, input bit vld, input logic [2:0] op,
                          input logic [31:0] d, input logic [31:0] s,
                          input logic [15:0] i16, input logic [4:0] i5);
        logic [31:0] exp_res;
        logic        exp_we;
        logic [2:0]  exp_len;
        logic        nxt_c;
        logic [32:0] wide;
        @(negedge clk);
        op_valid = vld; op_sel = op; dst_val = d; src_val = s; imm16 = i16; imm5 = i5;
        nxt_c   = model_c;
        exp_len = 3'd2;
        exp_we  = vld;
        exp_res = 32'd0;
        case (op)
            3'd0: exp_res = d >> (s & 32'd31);
            3'd1: begin exp_res = s >> (i16 & 16'd31); exp_len = 3'd4; end
            3'd2: exp_res = d >> i5;
            3'd3: exp_res = d - s;
            3'd4: begin
                exp_res = d - s;
                if (vld) nxt_c = ((d[31] ^ s[31]) & (d[31] ^ exp_res[31]));
            end
            3'd5: begin
                wide    = {1'b0, d} - {1'b0, s} - {32'd0, model_c};
                exp_res = wide[31:0];
                if (vld) nxt_c = ({1'b0, d} < ({1'b0, s} + {32'd0, model_c}));
            end
            default: exp_we = 1'b0;
        endcase
        #1;
        if (exp_we) chk(req, result, exp_res);
        chk(req, {31'd0, result_we}, {31'd0, exp_we});
        chk(req, {29'd0, insn_bytes}, {29'd0, exp_len});
        @(posedge clk);
        #1;
        model_c = nxt_c;
        chk(req, {31'd0, cond_out}, {31'd0, model_c});
    endtask

    logic [31:0] pats [0:7];

    initial begin
        pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001;
        pats[2] = 32'h7FFF_FFFF; pats[3] = 32'h8000_0000;
        pats[4] = 32'hFFFF_FFFF; pats[5] = 32'hA5C3_0F96;
        pats[6] = 32'h8000_0001; pats[7] = 32'h1234_5678;

        repeat (3) @(posedge clk);
        #1;
        chk("R1", {31'd0, cond_out}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int p = 2; p < 8; p++) begin
            for (int c = 0; c < 32; c++) begin
                // R2: count from source low bits, upper source bits set to prove masking
                run_op("R2", 1'b1, 3'd0, pats[p], {27'h5A5A5A5, c[4:0]}, 16'd0, 5'd0);
                // R3: immediate upper bits ignored
                run_op("R3", 1'b1, 3'd1, 32'd0, pats[p], {11'h7A5, c[4:0]}, 5'd0);
                // R4
                run_op("R4", 1'b1, 3'd2, pats[p], 32'hFFFF_FFFF, 16'd0, c[4:0]);
            end
        end

        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                run_op("R5", 1'b1, 3'd3, pats[a], pats[b], 16'd0, 5'd0);
                run_op("R6", 1'b1, 3'd4, pats[a], pats[b], 16'd0, 5'd0);
                // R7 chained directly after an overflow subtraction
                run_op("R7", 1'b1, 3'd5, pats[b], pats[a], 16'd0, 5'd0);
                run_op("R7", 1'b1, 3'd5, pats[a], pats[b], 16'd0, 5'd0);
            end
        end

        // R8 and R9 with the flag forced to each value first
        for (int f = 0; f < 2; f++) begin
            run_op("R7", 1'b1, 3'd5, 32'd0, {31'd0, f[0]}, 16'd0, 5'd0);
            run_op("R8", 1'b0, 3'd4, 32'h8000_0000, 32'd1, 16'd0, 5'd0);
            run_op("R8", 1'b0, 3'd5, 32'd0, 32'd5, 16'd0, 5'd0);
            run_op("R9", 1'b1, 3'd6, 32'h8000_0000, 32'd1, 16'd0, 5'd0);
            run_op("R9", 1'b1, 3'd7, 32'd0, 32'd9, 16'd0, 5'd0);
        end

        // R1 again: reset clears a set flag
        run_op("R6", 1'b1, 3'd4, 32'h8000_0000, 32'd1, 16'd0, 5'd0);
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1", {31'd0, cond_out}, 32'd0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule